// File: doc/BRIEF.md
# Five-State Toggle-Cell Counter

This block is a 3-bit synchronous counter that runs through a fixed five-state cycle of non-binary codes: 000, 010, 011, 101, 110, and then back to 000. It takes one step on every rising clock edge. There is no enable or count-request input, so the counter never pauses except while reset is held.

Each state bit lives in its own toggle cell. On a clock edge the cell's next value is its present value XOR its toggle control. A small combinational decoder reads the present state and produces the three toggle controls. It was minimised by treating the three codes that lie outside the cycle (001, 100, 111) as free.

Those free choices are pinned down so that every stray code rejoins the cycle on the very next clock. The toggle vector is brought out to a port so that the decoder and the cells can be checked separately.

Top module: `irr_tcounter`

## Requirements
- R1: While `rst` is high at a rising edge, `state_o` becomes 000 after that edge. The reset is synchronous and active-high.
- R2: With `rst` low, every rising edge moves `state_o` to the next code of the cycle 000 → 010 → 011 → 101 → 110 → 000, with no idle cycle.
- R3: Across any edge where `rst` is low, the new `state_o` equals the old `state_o` XOR the old `toggle_o`. Bit 2 is C, bit 1 is B and bit 0 is A.
- R4: In the cycle states, `toggle_o` (C,B,A) is as follows: 010 in 000, 001 in 010, 110 in 011, 011 in 101, and 110 in 110.
- R5: The unused codes recover in one clock. 001 drives toggles 010 and moves to 011. 100 drives toggles 010 and moves to 110. 111 drives toggles 111 and moves to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| state_o | output | 3 | Registered counter state, C at bit 2, A at bit 0 |
| toggle_o | output | 3 | Toggle controls decoded from the present state |

## Verification
The checker's stepping and recovery properties apply only to an edge whose previous edge also saw `rst` low. They also assume that the stored state changes only through the toggle cells. The bench plants each unused code by overriding the cell register. It does this only in the same instant it releases reset, so that the single edge which breaks the XOR relation is one the checker already excludes. Outside those planted points the counter free-runs for more than three full cycles. Every sample is compared against a table model and against the previous sample XOR the previous toggle vector.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int STATE_W = 3;
  localparam int BIT_C   = 2;
  localparam int BIT_B   = 1;
  localparam int BIT_A   = 0;

  typedef logic [STATE_W-1:0] code_t;

  // states of the cycle, in visiting order
  localparam code_t ST_0 = 3'b000;
  localparam code_t ST_1 = 3'b010;
  localparam code_t ST_2 = 3'b011;
  localparam code_t ST_3 = 3'b101;
  localparam code_t ST_4 = 3'b110;

  // codes outside the cycle
  localparam code_t UN_0 = 3'b001;
  localparam code_t UN_1 = 3'b100;
  localparam code_t UN_2 = 3'b111;

  localparam code_t RESET_CODE = ST_0;
endpackage

// File: rtl/irr_tlogic.sv
module irr_tlogic
  import irr_pkg::*;
(
  input  code_t cur_i,
  output code_t tog_o
);
  logic c, b, a;

  assign c = cur_i[BIT_C];
  assign b = cur_i[BIT_B];
  assign a = cur_i[BIT_A];

  // minimised with 001/100/111 as free, then fixed to one-step recovery
  always_comb begin
    tog_o        = '0;
    tog_o[BIT_C] = b & (a | c);
    tog_o[BIT_B] = ~b | a | c;
    tog_o[BIT_A] = (~c & b & ~a) | (c & a);
  end
endmodule

// File: rtl/irr_tstore.sv
module irr_tstore #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] t_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  // one toggle cell per bit
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) q_r[i] <= INIT[i];
      else     q_r[i] <= q_r[i] ^ t_i[i];
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/irr_tcounter.sv
module irr_tcounter
  import irr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [STATE_W-1:0] state_o,
  output logic [STATE_W-1:0] toggle_o
);
  code_t cur_s;
  code_t tog_s;

  irr_tlogic u_logic (
    .cur_i (cur_s),
    .tog_o (tog_s)
  );

  irr_tstore #(
    .W    (STATE_W),
    .INIT (RESET_CODE)
  ) u_store (
    .clk (clk),
    .rst (rst),
    .t_i (tog_s),
    .q_o (cur_s)
  );

  assign state_o  = cur_s;
  assign toggle_o = tog_s;
endmodule

// File: rtl/irr_tcounter_chk.sv
module irr_tcounter_chk
  import irr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [STATE_W-1:0] state_o,
  input logic [STATE_W-1:0] toggle_o
);
  logic live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    (rst && $past(rst)) |-> state_o == RESET_CODE);

  // R3
  xor_step_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> state_o == $past(state_o ^ toggle_o));

  // R2
  step_from0_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(state_o) == ST_0) |-> state_o == ST_1);

  // R2
  step_from1_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(state_o) == ST_1) |-> state_o == ST_2);

  // R2
  step_from2_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(state_o) == ST_2) |-> state_o == ST_3);

  // R2
  step_from3_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(state_o) == ST_3) |-> state_o == ST_4);

  // R2
  step_from4_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(state_o) == ST_4) |-> state_o == ST_0);

  // R4
  toggle_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    toggle_o != '0);

  // R5
  recover_chk: assert property (@(posedge clk) disable iff (rst)
    (live && ($past(state_o) == UN_0 || $past(state_o) == UN_1 ||
              $past(state_o) == UN_2))
    |-> (state_o == ST_0 || state_o == ST_2 || state_o == ST_4));
endmodule

bind irr_tcounter irr_tcounter_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .state_o  (state_o),
  .toggle_o (toggle_o)
);

// File: tb/irr_tcounter_tb_top.sv
`timescale 1ns/1ps
module irr_tcounter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] state_o;
  logic [2:0] toggle_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] s;
    logic [2:0] t;
    bit         chain;
    string      stag;
    string      ttag;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  irr_tcounter dut_i (
    .clk      (clk),
    .rst      (rst),
    .state_o  (state_o),
    .toggle_o (toggle_o)
  );

  // reference successor table (R2, R5)
  function automatic logic [2:0] succ(input logic [2:0] c);
    case (c)
      3'b000:  succ = 3'b010;
      3'b010:  succ = 3'b011;
      3'b011:  succ = 3'b101;
      3'b101:  succ = 3'b110;
      3'b110:  succ = 3'b000;
      3'b001:  succ = 3'b011;
      3'b100:  succ = 3'b110;
      default: succ = 3'b000;
    endcase
  endfunction

  task automatic push(input logic [2:0] s, input bit chain,
                      input string stag, input string ttag);
    item_t it;
    it.s = s; it.t = s ^ succ(s); it.chain = chain;
    it.stag = stag; it.ttag = ttag;
    sb_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    logic [2:0] ps, pt;
    bit have = 1'b0;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(state_o === it.s, it.stag, "state", state_o, it.s);
        check(toggle_o === it.t, it.ttag, "toggle", toggle_o, it.t);
        if (it.chain && have)
          check(state_o === (ps ^ pt), "R3", "state vs prev xor toggle",
                state_o, ps ^ pt);
        ps = state_o; pt = toggle_o; have = 1'b1;
      end
    end
  end

  // driver
  initial begin
    logic [2:0] ref_s;
    logic [2:0] unused [3];
    unused[0] = 3'b001; unused[1] = 3'b100; unused[2] = 3'b111;

    repeat (2) @(posedge clk);
    #1;
    ref_s = 3'b000;
    push(ref_s, 1'b0, "R1", "R4");
    rst = 1'b0;

    // more than three full cycles, free-running
    for (int k = 0; k < 17; k++) begin
      @(posedge clk); #1;
      ref_s = succ(ref_s);
      push(ref_s, 1'b1, "R2", "R4");
    end

    // each unused code planted as reset is released
    for (int u = 0; u < 3; u++) begin
      rst = 1'b1;
      @(posedge clk); #1;
      push(3'b000, 1'b0, "R1", "R4");
      @(posedge clk); #1;
      force dut_i.u_store.q_r = unused[u];
      #0.2;
      release dut_i.u_store.q_r;
      rst = 1'b0;
      ref_s = unused[u];
      push(ref_s, 1'b0, "R5", "R5");
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #1;
        ref_s = succ(ref_s);
        push(ref_s, 1'b1, (k == 0) ? "R5" : "R2", "R4");
      end
    end

    wait (sb_q.size() == 0);
    @(negedge clk); #1;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    #(5.0 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule